// File: doc/BRIEF.md
# Debounced Input-Change Detector Port

This block is a small general-purpose input port for a CPU. Six asynchronous pins are brought into the clock domain and can be read at any time as a 6-bit value. The four lowest pins also feed change-of-state detectors. Each detector samples its input on a slow tick that a fixed clock divide produces. It accepts a new level only when that level appears on two consecutive ticks, so short glitches and contact bounce are filtered out.

Each accepted transition, rising or falling, sets a sticky flag in a change register. The same register also shows the current filtered level of each monitored pin. The CPU reads the register with a one-cycle read strobe, and that read clears the flags. A 4-bit enable register selects which flags drive the level-held interrupt output.

Top module: `chg_detect_port`

## Requirements
- R1: `portData[i]` reads 1 when pin `i` is high and 0 when it is low, for all six pins, after a two-flop synchroniser (two clock cycles of latency).
- R2: Pins 4 and 5 have no detector: toggling them never sets any bit of `chgData[7:4]`.
- R3: The detectors sample once every `TICK_DIV` clock cycles (default 96, giving 38.4 kHz from a 3.6864 MHz clock), counting from the release of reset.
- R4: A monitored pin's new level is accepted only when it differs from the accepted level and is seen on two consecutive ticks. A pulse shorter than one tick period is never accepted. A held change is accepted within two tick periods plus the synchroniser latency.
- R5: Both rising and falling accepted transitions set the flag. The change register layout is: flag of monitored input `i` in `chgData[4+i]`, accepted level of input `i` in `chgData[i]`.
- R6: A `chgRd` pulse returns the current `chgData` in that cycle and clears all flags at the next edge. A flag that is newly set in the same cycle as the read stays set.
- R7: `ienWr` loads `ienData` into the enable mask (bit `i` enables flag `i`). `irq` is the OR of the enabled flags and stays asserted until those flags are cleared.
- R8: Reset clears flags and the enable mask and loads the accepted levels from the pins, so that no change is flagged for a pin that is static during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 6 | Asynchronous input pins |
| portData | output | 6 | Synchronised pin levels |
| chgRd | input | 1 | Read strobe for the change register; clears flags |
| chgData | output | 8 | Change flags [7:4], accepted levels [3:0] |
| ienWr | input | 1 | Write strobe for the interrupt enable mask |
| ienData | input | 4 | New interrupt enable mask |
| irq | output | 1 | Level interrupt, OR of enabled flags |

## Verification
The bench builds the block with `TICK_DIV` set to 4 instead of 96. This puts whole debounce windows, sub-tick glitches and repeated toggling within a few dozen cycles. The widths of the six pins and four detectors keep their default values, so the layout of the change register is checked exactly as delivered. A short divide also makes it practical to hold the read strobe high across an entire acceptance window, which is how the collision between setting a flag and clearing it by a read is exercised.

// File: rtl/chg_port_pkg.sv
package chg_port_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic sampleEn;   // slow sampling tick
    logic loadLevels; // after reset: copy synchronised pins into accepted levels
    logic clrFlags;   // change register read
  } chgStrobe_t;
endpackage

// File: rtl/chg_detect_ctrl.sv
module chg_detect_ctrl
  import chg_port_pkg::*;
#(
  parameter int TICK_DIV = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chgRd,
  output chgStrobe_t ctl
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
  localparam int INIT_CYC = 3; // sync depth plus one

  logic [CW-1:0] divCnt;
  logic [1:0]    initCnt;
  logic          loading;

  assign loading = (initCnt != 2'(INIT_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      initCnt <= '0;
    end else begin
      divCnt <= (divCnt == LAST) ? '0 : divCnt + 1'b1;
      if (loading) initCnt <= initCnt + 2'd1;
    end
  end

  always_comb begin
    ctl.sampleEn   = (divCnt == LAST);
    ctl.loadLevels = loading;
    ctl.clrFlags   = chgRd;
  end
endmodule

// File: rtl/chg_detect_dp.sv
module chg_detect_dp
  import chg_port_pkg::*;
#(
  parameter int NUM_IN  = 6,
  parameter int NUM_MON = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chgStrobe_t           ctl,
  input  logic [NUM_IN-1:0]    pinIn,
  input  logic                 ienWr,
  input  logic [NUM_MON-1:0]   ienData,
  output logic [NUM_IN-1:0]    portData,
  output logic [2*NUM_MON-1:0] chgData,
  output logic                 irq
);
  logic [NUM_IN-1:0]  syncA, syncB;
  logic [NUM_MON-1:0] accLvl, pend, flags, setMask, ienReg;

  // two-flop synchroniser on every pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  // one debouncer per monitored input
  for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
    logic differs;
    assign differs    = syncB[i] ^ accLvl[i];
    assign setMask[i] = ctl.sampleEn && !ctl.loadLevels && differs && pend[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accLvl[i] <= 1'b0;
        pend[i]   <= 1'b0;
      end else if (ctl.loadLevels) begin
        accLvl[i] <= syncB[i];
        pend[i]   <= 1'b0;
      end else if (ctl.sampleEn) begin
        if (!differs) begin
          pend[i] <= 1'b0;
        end else if (pend[i]) begin
          accLvl[i] <= syncB[i];
          pend[i]   <= 1'b0;
        end else begin
          pend[i] <= 1'b1;
        end
      end
    end
  end

  // sticky flags: a new set wins over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (ctl.clrFlags ? '0 : flags) | setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ienReg <= '0;
    else if (ienWr) ienReg <= ienData;
  end

  assign portData = syncB;
  assign chgData  = {flags, accLvl};
  assign irq      = |(flags & ienReg);
endmodule

// File: rtl/chg_detect_port.sv
module chg_detect_port
  import chg_port_pkg::*;
#(
  parameter int NUM_IN   = 6,
  parameter int NUM_MON  = 4,
  parameter int TICK_DIV = 96
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IN-1:0]    pinIn,
  output logic [NUM_IN-1:0]    portData,
  input  logic                 chgRd,
  output logic [2*NUM_MON-1:0] chgData,
  input  logic                 ienWr,
  input  logic [NUM_MON-1:0]   ienData,
  output logic                 irq
);
  chgStrobe_t ctl;

  chg_detect_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .chgRd(chgRd), .ctl(ctl)
  );

  chg_detect_dp #(.NUM_IN(NUM_IN), .NUM_MON(NUM_MON)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pinIn(pinIn),
    .ienWr(ienWr), .ienData(ienData), .portData(portData),
    .chgData(chgData), .irq(irq)
  );
endmodule

// File: rtl/chg_detect_port_chk.sv
module chg_detect_port_chk
  import chg_port_pkg::*;
#(
  parameter int NUM_MON  = 4,
  parameter int TICK_DIV = 96
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 chgRd,
  input logic                 ienWr,
  input logic [NUM_MON-1:0]   ienData,
  input logic [2*NUM_MON-1:0] chgData,
  input logic                 irq,
  input chgStrobe_t           ctl
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  logic [CW-1:0]      gap;
  logic [NUM_MON-1:0] ienShadow, flg, lvl;

  assign flg = chgData[2*NUM_MON-1:NUM_MON];
  assign lvl = chgData[NUM_MON-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap       <= '0;
      ienShadow <= '0;
    end else begin
      gap <= ctl.sampleEn ? '0 : gap + 1'b1;
      if (ienWr) ienShadow <= ienData;
    end
  end

  // R3: ticks exactly TICK_DIV cycles apart
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sampleEn |-> (gap == CW'(TICK_DIV - 1)));

  // R4: a flag can only rise at a sampling tick
  p_flag_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|(flg & ~$past(flg))) |-> $past(ctl.sampleEn));

  // R5: accepted levels move only at a tick or during the reset load
  p_level_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctl.sampleEn) && !$past(ctl.loadLevels)) |-> $stable(lvl));

  // R6: a read outside a tick leaves no flag set
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chgRd) && !$past(ctl.sampleEn)) |-> (flg == '0));

  // R7: interrupt follows the enabled flags
  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq == (|(flg & ienShadow)));

  // R8: no flag while the reset load is in progress
  p_no_flag_at_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLevels |-> (flg == '0));
endmodule

bind chg_detect_port chg_detect_port_chk #(.NUM_MON(NUM_MON), .TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .chgRd(chgRd), .ienWr(ienWr), .ienData(ienData),
  .chgData(chgData), .irq(irq), .ctl(ctl)
);

// File: tb/chg_detect_port_tb.sv
module chg_detect_port_tb;
  localparam int DIV = 4;

  logic       clk = 0;
  logic       rstN = 0;
  logic [5:0] pinIn = 6'b101010;
  logic [5:0] portData;
  logic       chgRd = 0;
  logic [7:0] chgData;
  logic       ienWr = 0;
  logic [3:0] ienData = 0;
  logic       irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  chg_detect_port #(.NUM_IN(6), .NUM_MON(4), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .portData(portData),
    .chgRd(chgRd), .chgData(chgData), .ienWr(ienWr), .ienData(ienData), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdClear();
    chgRd = 1; cyc(1); chgRd = 0; cyc(1);
  endtask

  task automatic t_reset();
    chk(chgData == 8'h0A, "R8 reset change reg", chgData, 8'h0A);
    chk(irq == 0, "R8 reset irq", irq, 0);
    chk(portData == 6'b101010, "R1 reset port", portData, 6'b101010);
    cyc(4 * DIV);
    chk(chgData[7:4] == 0, "R8 no spurious flag", chgData[7:4], 0);
  endtask

  task automatic t_plain();
    pinIn[5:4] = 2'b01; cyc(2);
    chk(portData == 6'b011010, "R1 port read", portData, 6'b011010);
    pinIn[5:4] = 2'b10; cyc(1);
    pinIn[5:4] = 2'b01; cyc(4 * DIV);
    chk(chgData == 8'h0A, "R2 upper pins unmonitored", chgData, 8'h0A);
  endtask

  task automatic t_rise_fall();
    pinIn[0] = 1; cyc(DIV + 2);
    chk(chgData[4] == 0, "R4 not accepted early", chgData[4], 0);
    cyc(DIV + 1);
    chk(chgData == 8'h1B, "R5 rise accepted", chgData, 8'h1B);
    rdClear();
    pinIn[3] = 0; cyc(2 * DIV + 3);
    chk(chgData == 8'h83, "R5 fall accepted", chgData, 8'h83);
    rdClear();
  endtask

  task automatic t_glitch();
    pinIn[2] = 1; cyc(DIV - 1);
    pinIn[2] = 0; cyc(4 * DIV);
    chk(chgData == 8'h03, "R4 glitch rejected", chgData, 8'h03);
  endtask

  task automatic t_read_clear();
    pinIn[1] = 0; cyc(2 * DIV + 3);
    chk(chgData == 8'h21, "R5 bit1 fall", chgData, 8'h21);
    chgRd = 1;
    chk(chgData == 8'h21, "R6 read returns value", chgData, 8'h21);
    cyc(1); chgRd = 0;
    chk(chgData == 8'h01, "R6 read clears flags", chgData, 8'h01);
  endtask

  task automatic t_irq();
    pinIn[2] = 1; cyc(2 * DIV + 3);
    chk(irq == 0, "R7 masked flag", irq, 0);
    ienData = 4'b0100; ienWr = 1; cyc(1); ienWr = 0;
    chk(irq == 1, "R7 enabled flag", irq, 1);
    cyc(3 * DIV);
    chk(irq == 1, "R7 irq held", irq, 1);
    rdClear();
    chk(irq == 0, "R7 irq drops after read", irq, 0);
  endtask

  task automatic t_collision();
    bit seen = 0;
    chgRd = 1;
    pinIn[0] = 0;
    for (int k = 0; k < 3 * DIV + 4; k++) begin
      cyc(1);
      if (chgData[4]) seen = 1;
    end
    chgRd = 0; cyc(1);
    chk(seen == 1, "R6 set wins over read", seen, 1);
    chk(chgData == 8'h04, "R6 cleared after read", chgData, 8'h04);
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    cyc(5);
    t_reset();
    t_plain();
    t_rise_fall();
    t_glitch();
    t_read_clear();
    t_irq();
    t_collision();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule